// File: doc/BRIEF.md
# GPIO and Control Register File

This block is a small register file of 16-bit registers on a plain memory-mapped bus. The bus has one address, a write enable with write data and a read enable with read data. Six registers are plain storage for mode, clock divider, clock control and three interrupt-related words. These words only hold what software writes into them; nothing in the block acts on them. A power-control register adds a side effect on write. A fixed read-only status word reads back a constant. Three registers handle the pins: a direction register, and a level register that two offsets expose.

Sixteen output pins carry the level ANDed with direction. They are refreshed only when software writes the direction or the level. Sixteen external input lines carry a per-line event strobe and a value. Each event overwrites one bit of the level register, but it does not refresh the pins. The pins only show such a change after the next direction or level write.

There is no sequencing. Every register is a single-state holder that updates on a rising edge. Reads are combinational from the current register state.

Top module: `gpreg_top`

## Requirements
- R1: Only address bits [5:0] are decoded, and higher address bits are ignored. Offsets: 0x00 mode, 0x04 divider, 0x08 status, 0x0C power, 0x10 clock control, 0x14 irq raw, 0x18 irq mask, 0x1C irq status, 0x20 direction, 0x24 level (write port), 0x28 level (read port).
- R2: Write data is cut to bits [15:0]. A storage register read at its offset returns the last value written to it.
- R3: A write to the power register stores the data. When data bit 7 is 1, bits 15 and 6 are also set (data OR 0x8040).
- R4: The status register reads 0x0002, and writes to offset 0x08 change nothing.
- R5: A write to offset 0x24 or 0x28 stores the data ANDed with the current direction into the level register. A read at either offset returns the level. A read at 0x20 returns the direction.
- R6: On the edge of a direction or level write, each pin whose bit of (level AND direction) differs from its driven value takes the new bit. That bit is computed from the register values after that edge. The new pin value is visible after that edge.
- R7: The pins hold their value in every cycle without a write to direction or level. This includes cycles with input-line events.
- R8: When line_valid[i] is 1 at an edge, level bit i takes line_level[i]. A bus write to the level register in the same cycle takes priority for all bits.
- R9: A read at an undefined offset returns 0. This includes unaligned offsets and 0x2C to 0x3F. A write there changes no register.
- R10: After reset every register reads 0 except status, and all pins are 0.
- R11: bus_rdata is 0 whenever bus_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (12) | Byte address; only bits [5:0] decoded |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | WDATA_W (32) | Write data; bits [15:0] used |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | REG_W (16) | Combinational read data |
| line_valid | input | REG_W (16) | Per-line input event strobe |
| line_level | input | REG_W (16) | Per-line input value |
| pin_out | output | REG_W (16) | Output pins, level AND direction |

## Verification
Read data is combinational, so the bench samples it 1 ns after it drives the address at the falling edge, in the same cycle. Register writes, input-line events and pin updates all land on the next rising edge. The bench therefore advances its model at that edge and compares the pins and the read-back at the following falling edge, one cycle after the stimulus. Directed reads that follow a write are issued one cycle later for the same reason. The checker's properties use the same one-edge spacing (|=>).

// File: rtl/gpreg_pkg.sv
package gpreg_pkg;
    localparam int OFF_W = 6;

    localparam logic [OFF_W-1:0] OFF_MODE = 6'h00;
    localparam logic [OFF_W-1:0] OFF_DIV  = 6'h04;
    localparam logic [OFF_W-1:0] OFF_STAT = 6'h08;
    localparam logic [OFF_W-1:0] OFF_PWR  = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_CLK  = 6'h10;
    localparam logic [OFF_W-1:0] OFF_IRAW = 6'h14;
    localparam logic [OFF_W-1:0] OFF_IMSK = 6'h18;
    localparam logic [OFF_W-1:0] OFF_IST  = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_DIR  = 6'h20;
    localparam logic [OFF_W-1:0] OFF_LVLW = 6'h24;
    localparam logic [OFF_W-1:0] OFF_LVLR = 6'h28;

    typedef enum logic [3:0] {
        S_MODE, S_DIV, S_STAT, S_PWR, S_CLK, S_IRAW,
        S_IMSK, S_IST, S_DIR, S_LVLW, S_LVLR
    } sel_e;

    localparam int NSEL   = 11;
    localparam int NPLAIN = 6;
endpackage

// File: rtl/gpreg_decode.sv
module gpreg_decode
    import gpreg_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output logic [NSEL-1:0]  sel
);
    always_comb begin
        sel = '0;
        case (off)
            OFF_MODE: sel[S_MODE] = 1'b1;
            OFF_DIV:  sel[S_DIV]  = 1'b1;
            OFF_STAT: sel[S_STAT] = 1'b1;
            OFF_PWR:  sel[S_PWR]  = 1'b1;
            OFF_CLK:  sel[S_CLK]  = 1'b1;
            OFF_IRAW: sel[S_IRAW] = 1'b1;
            OFF_IMSK: sel[S_IMSK] = 1'b1;
            OFF_IST:  sel[S_IST]  = 1'b1;
            OFF_DIR:  sel[S_DIR]  = 1'b1;
            OFF_LVLW: sel[S_LVLW] = 1'b1;
            OFF_LVLR: sel[S_LVLR] = 1'b1;
            default:  sel = '0;
        endcase
    end
endmodule

// File: rtl/gpreg_store.sv
module gpreg_store #(
    parameter int W = 16,
    parameter int N = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wr,
    input  logic [W-1:0]        wd,
    output logic [N-1:0][W-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[g] <= '0;
            else if (wr[g])
                q[g] <= wd;
        end
    end
endmodule

// File: rtl/gpreg_power.sv
module gpreg_power #(
    parameter int           W     = 16,
    parameter int           TRIG  = 7,
    parameter logic [W-1:0] FORCE = 16'h8040
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);
    logic [W-1:0] next_q;

    always_comb begin
        next_q = wd;
        if (wd[TRIG])
            next_q = wd | FORCE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr)
            q <= next_q;
    end
endmodule

// File: rtl/gpreg_gpio.sv
module gpreg_gpio #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_wr,
    input  logic         lvl_wr,
    input  logic [W-1:0] wd,
    input  logic [W-1:0] in_valid,
    input  logic [W-1:0] in_level,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lvl_q,
    output logic [W-1:0] pin_out
);
    logic [W-1:0] dir_d;
    logic [W-1:0] lvl_d;
    logic [W-1:0] eff_d;
    logic         reeval;

    always_comb begin
        dir_d  = dir_wr ? wd : dir_q;
        lvl_d  = lvl_wr ? (wd & dir_q)
                        : ((lvl_q & ~in_valid) | (in_level & in_valid));
        eff_d  = lvl_d & dir_d;
        reeval = dir_wr | lvl_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            lvl_q <= '0;
        end else begin
            dir_q <= dir_d;
            lvl_q <= lvl_d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic drv_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                drv_q <= 1'b0;
            else if (reeval && (eff_d[i] != drv_q))
                drv_q <= eff_d[i];
        end
        assign pin_out[i] = drv_q;
    end
endmodule

// File: rtl/gpreg_top.sv
module gpreg_top
    import gpreg_pkg::*;
#(
    parameter int           ADDR_W   = 12,
    parameter int           WDATA_W  = 32,
    parameter int           REG_W    = 16,
    parameter logic [15:0]  STAT_VAL = 16'h0002
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [WDATA_W-1:0] bus_wdata,
    input  logic               bus_rd,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [REG_W-1:0]   line_valid,
    input  logic [REG_W-1:0]   line_level,
    output logic [REG_W-1:0]   pin_out
);
    logic [NSEL-1:0]              sel;
    logic [REG_W-1:0]             wd16;
    logic [NPLAIN-1:0]            plain_wr;
    logic [NPLAIN-1:0][REG_W-1:0] plain_q;
    logic [REG_W-1:0]             pwr_q;
    logic [REG_W-1:0]             dir_q;
    logic [REG_W-1:0]             lvl_q;
    logic [REG_W-1:0]             vals [NSEL];
    logic                         unused_hi;

    assign wd16      = bus_wdata[REG_W-1:0];
    assign unused_hi = ^{bus_addr[ADDR_W-1:OFF_W], bus_wdata[WDATA_W-1:REG_W]};

    gpreg_decode u_dec (
        .off (bus_addr[OFF_W-1:0]),
        .sel (sel)
    );

    assign plain_wr = {NPLAIN{bus_we}} &
                      {sel[S_IST], sel[S_IMSK], sel[S_IRAW],
                       sel[S_CLK], sel[S_DIV], sel[S_MODE]};

    gpreg_store #(.W(REG_W), .N(NPLAIN)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (plain_wr),
        .wd    (wd16),
        .q     (plain_q)
    );

    gpreg_power #(.W(REG_W)) u_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_we && sel[S_PWR]),
        .wd    (wd16),
        .q     (pwr_q)
    );

    gpreg_gpio #(.W(REG_W)) u_gpio (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_wr   (bus_we && sel[S_DIR]),
        .lvl_wr   (bus_we && (sel[S_LVLW] || sel[S_LVLR])),
        .wd       (wd16),
        .in_valid (line_valid),
        .in_level (line_level),
        .dir_q    (dir_q),
        .lvl_q    (lvl_q),
        .pin_out  (pin_out)
    );

    always_comb begin
        vals[S_MODE] = plain_q[0];
        vals[S_DIV]  = plain_q[1];
        vals[S_STAT] = STAT_VAL[REG_W-1:0];
        vals[S_PWR]  = pwr_q;
        vals[S_CLK]  = plain_q[2];
        vals[S_IRAW] = plain_q[3];
        vals[S_IMSK] = plain_q[4];
        vals[S_IST]  = plain_q[5];
        vals[S_DIR]  = dir_q;
        vals[S_LVLW] = lvl_q;
        vals[S_LVLR] = lvl_q;
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NSEL; k++)
            if (bus_rd && sel[k])
                bus_rdata = bus_rdata | vals[k];
    end
endmodule

// File: rtl/gpreg_chk.sv
module gpreg_chk
    import gpreg_pkg::*;
#(
    parameter int          W        = 16,
    parameter logic [15:0] STAT_VAL = 16'h0002
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  off,
    input logic              we,
    input logic              rd,
    input logic [W-1:0]      wd,
    input logic [W-1:0]      rdata,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      lvl_q,
    input logic [W-1:0]      pwr_q,
    input logic [NSEL-1:0]   sel
);
    logic gpio_wr;
    assign gpio_wr = we && (off == OFF_DIR || off == OFF_LVLW || off == OFF_LVLR);

    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    p_pwr_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && off == OFF_PWR && wd[7]) |=> (pwr_q[15] && pwr_q[6]));

    p_stat_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && off == OFF_STAT) |-> (rdata == STAT_VAL[W-1:0]));

    p_lvl_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (off == OFF_LVLW || off == OFF_LVLR)) |=> (lvl_q == ($past(wd) & $past(dir_q))));

    p_pin_in_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~dir_q) == '0);

    p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_wr |=> $stable(pin_out));

    p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (rdata == '0));

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (rdata == '0));
endmodule

bind gpreg_top gpreg_chk #(.W(REG_W), .STAT_VAL(STAT_VAL)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .off     (bus_addr[5:0]),
    .we      (bus_we),
    .rd      (bus_rd),
    .wd      (bus_wdata[REG_W-1:0]),
    .rdata   (bus_rdata),
    .pin_out (pin_out),
    .dir_q   (dir_q),
    .lvl_q   (lvl_q),
    .pwr_q   (pwr_q),
    .sel     (sel)
);

// File: tb/sim_gpreg_top.sv
`timescale 1ns/1ps
module sim_gpreg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] line_valid = '0;
    logic [15:0] line_level = '0;
    logic [15:0] pin_out;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_plain [6];
    logic [15:0] m_pwr, m_dir, m_lvl, m_out;

    always #2.5 clk = ~clk;

    gpreg_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .line_valid (line_valid),
        .line_level (line_level),
        .pin_out    (pin_out)
    );

    function automatic int plain_idx(input logic [5:0] o);
        case (o)
            6'h00: return 0;
            6'h04: return 1;
            6'h10: return 2;
            6'h14: return 3;
            6'h18: return 4;
            6'h1C: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] exp_read(input logic [5:0] o);
        if (plain_idx(o) >= 0) return m_plain[plain_idx(o)];
        case (o)
            6'h08: return 16'h0002;
            6'h0C: return m_pwr;
            6'h20: return m_dir;
            6'h24, 6'h28: return m_lvl;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_for(input logic [5:0] o, input logic rd);
        if (!rd) return "R11";
        if (plain_idx(o) >= 0) return "R2";
        case (o)
            6'h08: return "R4";
            6'h0C: return "R3";
            6'h20, 6'h24, 6'h28: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%04h expected=%04h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 6; k++) m_plain[k] = '0;
        m_pwr = '0; m_dir = '0; m_lvl = '0; m_out = '0;
    endtask

    task automatic model_edge(input logic [11:0] a, input logic we, input logic [31:0] wd,
                              input logic [15:0] lv, input logic [15:0] ll);
        logic [5:0]  o;
        logic [15:0] w, lvl_n, dir_n;
        o = a[5:0];
        w = wd[15:0];
        lvl_n = (m_lvl & ~lv) | (ll & lv);
        dir_n = m_dir;
        if (we) begin
            if (o == 6'h24 || o == 6'h28) lvl_n = w & m_dir;
            if (o == 6'h20) dir_n = w;
            if (o == 6'h0C) m_pwr = w[7] ? (w | 16'h8040) : w;
            if (plain_idx(o) >= 0) m_plain[plain_idx(o)] = w;
        end
        m_lvl = lvl_n;
        m_dir = dir_n;
        if (we && (o == 6'h20 || o == 6'h24 || o == 6'h28))
            m_out = lvl_n & dir_n;
    endtask

    task automatic cyc(input logic [11:0] a, input logic we, input logic [31:0] wd,
                       input logic rd, input logic [15:0] lv, input logic [15:0] ll);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; bus_rd = rd;
        line_valid = lv; line_level = ll;
        #1;
        check(bus_rdata, rd ? exp_read(a[5:0]) : 16'h0000, tag_for(a[5:0], rd));
        check(pin_out, m_out, "R6/R7 pins");
        @(posedge clk);
        model_edge(a, we, wd, lv, ll);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(a, 1'b1, d, 1'b0, '0, '0);
    endtask

    task automatic peek(input logic [11:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0; bus_wdata = '0; bus_rd = 1'b1;
        line_valid = '0; line_level = '0;
        #1;
        check(bus_rdata, exp, tag);
        @(posedge clk);
        model_edge(a, 1'b0, '0, '0, '0);
    endtask

    task automatic pins(input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_rd = 1'b0; line_valid = '0;
        #1;
        check(pin_out, exp, tag);
        @(posedge clk);
        model_edge(bus_addr, 1'b0, '0, '0, '0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [11:0] a;
        logic [5:0]  offs [14];
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        offs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C,
                 6'h20, 6'h24, 6'h28, 6'h2C, 6'h02, 6'h3C};
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        pins(16'h0000, "R10 pins after reset");
        peek(12'h000, 16'h0000, "R10 mode after reset");
        peek(12'h020, 16'h0000, "R10 dir after reset");
        peek(12'h008, 16'h0002, "R4 status after reset");

        // R2: truncation
        wr(12'h000, 32'h1234_5678);
        peek(12'h000, 16'h5678, "R2 truncation");

        // R3: power side effect
        wr(12'h00C, 32'h0000_0080);
        peek(12'h00C, 16'h80C0, "R3 bit7 forces");
        wr(12'h00C, 32'h0000_0001);
        peek(12'h00C, 16'h0001, "R3 no force");

        // R4: status write ignored
        wr(12'h008, 32'h0000_FFFF);
        peek(12'h008, 16'h0002, "R4 write ignored");

        // R5/R6: level masked by direction
        wr(12'h020, 32'h0000_00FF);
        pins(16'h0000, "R6 dir write, level 0");
        wr(12'h024, 32'h0000_FFFF);
        pins(16'h00FF, "R6 after level write");
        peek(12'h028, 16'h00FF, "R5 masked via read port");

        // R1: upper address bits ignored
        wr(12'hF28, 32'h0000_0F0F);
        peek(12'h124, 16'h000F, "R1 alias");
        pins(16'h000F, "R6 after aliased write");

        // R9: undefined offset
        wr(12'h02C, 32'h0000_FFFF);
        peek(12'h02C, 16'h0000, "R9 undefined read");
        peek(12'h024, 16'h000F, "R9 level unchanged");

        // R8/R7: input event changes level but not pins
        cyc(12'h000, 1'b0, '0, 1'b0, 16'h0100, 16'h0100);
        pins(16'h000F, "R7 pins hold after input event");
        peek(12'h024, 16'h010F, "R8 input event sets bit");

        // R8: bus write wins over input line
        cyc(12'h024, 1'b1, 32'h0000_0003, 1'b0, 16'h00F0, 16'h00F0);
        peek(12'h024, 16'h0003, "R8 bus priority");

        // R6: direction write re-evaluates
        wr(12'h024, 32'h0000_00FF);
        wr(12'h020, 32'h0000_000F);
        pins(16'h000F, "R6 dir shrink");

        // R11: read disabled
        cyc(12'h024, 1'b0, '0, 1'b0, '0, '0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            a = {$urandom_range(0, 63), offs[$urandom_range(0, 13)]};
            cyc(a, ($urandom_range(0, 1) == 1), $urandom,
                ($urandom_range(0, 3) != 0),
                $urandom & $urandom & 32'hFFFF, $urandom & 32'hFFFF);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule